// File: doc/BRIEF.md
# NAND Page Program and Erase Core

This block is the storage engine of a small NAND flash model. It holds every page of the device in on-chip storage. Each page has a main area and a spare area that is one thirty-second of the main size. Host logic opens a program sequence with a page and column and streams bytes into a page buffer. It then commits the buffer into the array. A commit can only clear bits, because each buffered byte is ANDed into the stored byte. Whole blocks of pages can be erased back to all-ones. A read points the output at a page and start column, and each data-out request moves on by one byte.

Commands arrive as a one-cycle start pulse with a 2-bit operation code. Commit and erase hold the ready flag low for a fixed, parameterised window. During that window a byte-serial walker updates the array. A write-protect level blocks both commit and erase. A spare-select level decides whether a read continues into the spare bytes.

Top module: `nand_core`

## Requirements
- R1: A page is 2^PAGE_SHIFT main bytes followed by 2^(PAGE_SHIFT-5) spare bytes (64 + 2 = 66 at the defaults). Column c addresses byte c of that 66-byte sequence.
- R2: After reset every array byte reads 0xFF, ready is high, and doutByte is 0xFF until a read has been started.
- R3: opCode 2'b01 latches the program page and column and empties the buffer. opCode 2'b10 (commit) ANDs buffered byte i into the latched page at column+i. Bytes that would land past the page's last spare byte are dropped.
- R4: The buffer accepts at most one full page plus spare (66 bytes) per program sequence. Further data-in bytes are dropped.
- R5: opCode 2'b11 (erase) clears the low ERASE_SHIFT bits of opPage. It then sets every main and spare byte of the 2^ERASE_SHIFT pages of that block to 0xFF and leaves other blocks unchanged.
- R6: When wrAllow is low, a commit or an erase leaves the array unchanged and ready stays high.
- R7: opCode 2'b00 (read) places doutByte at opCol of opPage, and each doutReq advances one byte. The readable range ends after the last main byte when spareEn is low and after the last spare byte when it is high. Past that end doutByte is 0xFF.
- R8: A commit whose latched page, or an erase whose opPage, is at or above NUM_PAGES has no effect and keeps ready high. A read of such a page leaves the current read position unchanged.
- R9: An accepted commit or erase drives ready low for exactly BUSY_CYCLES cycles, starting with the cycle after the accepting edge.
- R10: Data-in bytes and start pulses that arrive while ready is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opStart | input | 1 | One-cycle operation start |
| opCode | input | 2 | 00 read, 01 program begin, 10 commit, 11 erase |
| opPage | input | 5 | Page number (one bit wider than needed so that out-of-range pages can be expressed) |
| opCol | input | 7 | Start column within the page |
| wrAllow | input | 1 | High allows commit and erase |
| spareEn | input | 1 | High lets reads continue into the spare bytes |
| dinValid | input | 1 | Data-in byte strobe |
| dinByte | input | 8 | Data-in byte |
| doutReq | input | 1 | Advance read position by one byte |
| doutByte | output | 8 | Byte at the current read position |
| ready | output | 1 | High when idle, low during commit or erase |

## Verification
A read or program-begin takes effect at the rising edge that samples the start pulse. doutByte therefore shows the first byte one cycle later, and every doutReq moves it on at the next edge. Ready falls at the edge that accepts a commit or erase and rises again BUSY_CYCLES edges later. The array contents are final by then, because the walker needs fewer cycles than the window. The bench drives every input on the falling clock edge and reads outputs on the following falling edge, after all register updates have settled. It counts falling edges with ready low to measure the busy window.

// File: rtl/nand_pkg.sv
package nand_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_PROG   = 2'b01,
    OP_COMMIT = 2'b10,
    OP_ERASE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_COMMIT = 2'd1,
    S_ERASE  = 2'd2
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bufWr;    // store dinByte into page buffer at bufIdx
    logic arrWr;    // update array byte at arrIdx
    logic arrFill;  // 1: write 0xFF, 0: AND with buffer byte
  } strobe_t;
endpackage

// File: rtl/nand_dp.sv
module nand_dp
  import nand_pkg::*;
#(
  parameter int PAGE_SHIFT = 6,
  parameter int NUM_PAGES  = 16,
  localparam int MAIN_B = 1 << PAGE_SHIFT,
  localparam int PB     = MAIN_B + (1 << (PAGE_SHIFT - 5)),
  localparam int TOTAL  = NUM_PAGES * PB,
  localparam int CW     = $clog2(PB + 1),
  localparam int AW     = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [CW-1:0] bufIdx,
  input  logic [AW-1:0] arrIdx,
  input  logic [AW-1:0] rdIdx,
  input  logic          rdInRange,
  input  logic [7:0]    dinByte,
  output logic [7:0]    doutByte
);
  logic [7:0] mem     [TOTAL];
  logic [7:0] pageBuf [PB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
      for (int j = 0; j < PB; j++) pageBuf[j] <= 8'hFF;
    end else begin
      if (stb.bufWr) pageBuf[bufIdx] <= dinByte;
      if (stb.arrWr) begin
        if (stb.arrFill) mem[arrIdx] <= 8'hFF;
        else             mem[arrIdx] <= mem[arrIdx] & pageBuf[bufIdx];
      end
    end
  end

  always_comb doutByte = rdInRange ? mem[rdIdx] : 8'hFF;

  // R3
  and_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.arrWr && !stb.arrFill) |=> ((mem[$past(arrIdx)] & ~$past(mem[arrIdx])) == 8'h00));
  // R5
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.arrWr && stb.arrFill) |=> (mem[$past(arrIdx)] == 8'hFF));
endmodule

// File: rtl/nand_ctrl.sv
module nand_ctrl
  import nand_pkg::*;
#(
  parameter int PAGE_SHIFT  = 6,
  parameter int NUM_PAGES   = 16,
  parameter int ERASE_SHIFT = 2,
  parameter int BUSY_CYCLES = 300,
  localparam int MAIN_B    = 1 << PAGE_SHIFT,
  localparam int PB        = MAIN_B + (1 << (PAGE_SHIFT - 5)),
  localparam int TOTAL     = NUM_PAGES * PB,
  localparam int BLK_PAGES = 1 << ERASE_SHIFT,
  localparam int BLK_BYTES = BLK_PAGES * PB,
  localparam int CW        = $clog2(PB + 1),
  localparam int AW        = $clog2(TOTAL),
  localparam int AXW       = AW + 1,
  localparam int PGW       = $clog2(NUM_PAGES) + 1,
  localparam int WW        = $clog2(BLK_BYTES + 1),
  localparam int BW        = $clog2(BUSY_CYCLES + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opStart,
  input  logic [1:0]     opCode,
  input  logic [PGW-1:0] opPage,
  input  logic [CW-1:0]  opCol,
  input  logic           wrAllow,
  input  logic           spareEn,
  input  logic           dinValid,
  input  logic           doutReq,
  output logic           ready,
  output strobe_t        stb,
  output logic [CW-1:0]  bufIdx,
  output logic [AW-1:0]  arrIdx,
  output logic [AW-1:0]  rdIdx,
  output logic           rdInRange
);
  ctrl_state_e    state;
  logic [BW-1:0]  busyCnt;
  logic [WW-1:0]  walkIdx;
  logic [CW-1:0]  walkLen;
  logic [CW-1:0]  bufCount;
  logic [PGW-1:0] progPage;
  logic [CW-1:0]  progCol;
  logic [AXW-1:0] opBase;
  logic [PGW-1:0] rdPage;
  logic [CW-1:0]  rdCol;
  logic           rdValid;

  op_e            opKind;
  logic           accept, pageOk, progOk, walkDone;
  logic [CW-1:0]  rdLimit;
  logic [WW:0]    colSum;
  logic [AXW-1:0] arrIdxWide;
  logic [PGW-1:0] alignedPage;

  always_comb begin
    opKind      = op_e'(opCode);
    ready       = (state == S_IDLE);
    accept      = opStart && ready;
    pageOk      = opPage < PGW'(NUM_PAGES);
    progOk      = progPage < PGW'(NUM_PAGES);
    alignedPage = opPage & ~PGW'(BLK_PAGES - 1);
    rdLimit     = spareEn ? CW'(PB) : CW'(MAIN_B);
    rdInRange   = rdValid && (rdCol < rdLimit);
    rdIdx       = AW'(rdPage) * AW'(PB) + AW'(rdCol);
    colSum      = (WW + 1)'(progCol) + (WW + 1)'(walkIdx);

    case (state)
      S_COMMIT: walkDone = (walkIdx >= WW'(walkLen)) || (colSum >= (WW + 1)'(PB));
      S_ERASE:  walkDone = walkIdx >= WW'(BLK_BYTES);
      default:  walkDone = 1'b1;
    endcase

    if (state == S_ERASE) arrIdxWide = opBase + AXW'(walkIdx);
    else                  arrIdxWide = opBase + AXW'(progCol) + AXW'(walkIdx);
    arrIdx = arrIdxWide[AW-1:0];

    stb.arrWr   = (state != S_IDLE) && !walkDone && (arrIdxWide < AXW'(TOTAL));
    stb.arrFill = (state == S_ERASE);
    stb.bufWr   = ready && dinValid && !opStart && (bufCount < CW'(PB));
    bufIdx      = (state == S_COMMIT) ? walkIdx[CW-1:0] : bufCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      busyCnt  <= '0;
      walkIdx  <= '0;
      walkLen  <= '0;
      bufCount <= '0;
      progPage <= '0;
      progCol  <= '0;
      opBase   <= '0;
      rdPage   <= '0;
      rdCol    <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (stb.bufWr) bufCount <= bufCount + 1'b1;
      if (doutReq && rdInRange) rdCol <= rdCol + 1'b1;

      if (state == S_IDLE) begin
        if (accept) begin
          case (opKind)
            OP_READ: if (pageOk) begin
              rdPage  <= opPage;
              rdCol   <= opCol;
              rdValid <= 1'b1;
            end
            OP_PROG: begin
              progPage <= opPage;
              progCol  <= opCol;
              bufCount <= '0;
            end
            OP_COMMIT: if (wrAllow && progOk) begin
              state    <= S_COMMIT;
              opBase   <= AXW'(progPage) * AXW'(PB);
              walkIdx  <= '0;
              walkLen  <= bufCount;
              bufCount <= '0;
              busyCnt  <= BW'(BUSY_CYCLES - 1);
            end
            OP_ERASE: if (wrAllow && pageOk) begin
              state   <= S_ERASE;
              opBase  <= AXW'(alignedPage) * AXW'(PB);
              walkIdx <= '0;
              busyCnt <= BW'(BUSY_CYCLES - 1);
            end
            default: ;
          endcase
        end
      end else begin
        if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
        if (!walkDone) walkIdx <= walkIdx + 1'b1;
        if (busyCnt == '0 && walkDone) state <= S_IDLE;
      end
    end
  end

  // R4
  bufcnt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufCount <= CW'(PB));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ($stable(bufCount) && $stable(rdPage) && $stable(progPage)));
  // R9
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(busyCnt) == '0));
  // R6
  protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !wrAllow && (opCode[1] == 1'b1)) |=> ready);
  // R7
  rdcol_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdCol <= CW'(PB) || $stable(rdCol) || $past(accept));
endmodule

// File: rtl/nand_core.sv
module nand_core
  import nand_pkg::*;
#(
  parameter int PAGE_SHIFT  = 6,
  parameter int NUM_PAGES   = 16,
  parameter int ERASE_SHIFT = 2,
  parameter int BUSY_CYCLES = 300,
  localparam int PB  = (1 << PAGE_SHIFT) + (1 << (PAGE_SHIFT - 5)),
  localparam int CW  = $clog2(PB + 1),
  localparam int AW  = $clog2(NUM_PAGES * PB),
  localparam int PGW = $clog2(NUM_PAGES) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opStart,
  input  logic [1:0]     opCode,
  input  logic [PGW-1:0] opPage,
  input  logic [CW-1:0]  opCol,
  input  logic           wrAllow,
  input  logic           spareEn,
  input  logic           dinValid,
  input  logic [7:0]     dinByte,
  input  logic           doutReq,
  output logic [7:0]     doutByte,
  output logic           ready
);
  strobe_t       stb;
  logic [CW-1:0] bufIdx;
  logic [AW-1:0] arrIdx;
  logic [AW-1:0] rdIdx;
  logic          rdInRange;

  nand_ctrl #(
    .PAGE_SHIFT(PAGE_SHIFT), .NUM_PAGES(NUM_PAGES),
    .ERASE_SHIFT(ERASE_SHIFT), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opCode(opCode),
    .opPage(opPage), .opCol(opCol), .wrAllow(wrAllow), .spareEn(spareEn),
    .dinValid(dinValid), .doutReq(doutReq), .ready(ready), .stb(stb),
    .bufIdx(bufIdx), .arrIdx(arrIdx), .rdIdx(rdIdx), .rdInRange(rdInRange)
  );

  nand_dp #(
    .PAGE_SHIFT(PAGE_SHIFT), .NUM_PAGES(NUM_PAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bufIdx(bufIdx), .arrIdx(arrIdx),
    .rdIdx(rdIdx), .rdInRange(rdInRange), .dinByte(dinByte),
    .doutByte(doutByte)
  );
endmodule

// File: tb/nand_core_tb.sv
module nand_core_tb;
  localparam int PB    = 66;
  localparam int MAINB = 64;
  localparam int NPG   = 16;
  localparam int BUSY  = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opStart = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic [4:0] opPage = '0;
  logic [6:0] opCol = '0;
  logic       wrAllow = 1'b1;
  logic       spareEn = 1'b1;
  logic       dinValid = 1'b0;
  logic [7:0] dinByte = '0;
  logic       doutReq = 1'b0;
  logic [7:0] doutByte;
  logic       ready;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [NPG*PB];

  always #10 clk = ~clk;

  nand_core #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opCode(opCode),
    .opPage(opPage), .opCol(opCol), .wrAllow(wrAllow), .spareEn(spareEn),
    .dinValid(dinValid), .dinByte(dinByte), .doutReq(doutReq),
    .doutByte(doutByte), .ready(ready)
  );

  typedef struct packed {
    logic [4:0] page;
    logic [6:0] col;
    logic [7:0] n;
    logic [7:0] fill;
    logic [7:0] expFirst;
  } vec_t;

  localparam vec_t TABLE [6] = '{
    '{5'd1,  7'd0,  8'd10, 8'hA5, 8'hA5},
    '{5'd2,  7'd0,  8'd8,  8'hF0, 8'hF0},
    '{5'd2,  7'd0,  8'd8,  8'h3C, 8'h30},
    '{5'd3,  7'd60, 8'd10, 8'h5A, 8'h5A},
    '{5'd5,  7'd64, 8'd2,  8'h11, 8'h11},
    '{5'd15, 7'd0,  8'd4,  8'hC3, 8'hC3}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] code, input logic [4:0] page, input logic [6:0] col);
    opStart = 1'b1; opCode = code; opPage = page; opCol = col;
    @(negedge clk);
    opStart = 1'b0;
  endtask

  task automatic pushData(input int n, input logic [7:0] fill);
    for (int i = 0; i < n; i++) begin
      dinValid = 1'b1; dinByte = fill ^ 8'(i);
      @(negedge clk);
    end
    dinValid = 1'b0;
  endtask

  task automatic modelCommit(input int page, input int col, input int n, input logic [7:0] fill);
    for (int i = 0; i < n && i < PB; i++)
      if (col + i < PB) model[page*PB + col + i] &= (fill ^ 8'(i));
  endtask

  task automatic waitBusy(output int cnt);
    cnt = 0;
    while (!ready) begin cnt++; @(negedge clk); end
  endtask

  task automatic chkRead(input int page, input int col, input int n, input logic spare, input string req);
    int lim;
    logic [7:0] exp;
    spareEn = spare;
    lim = spare ? PB : MAINB;
    doOp(2'b00, 5'(page), 7'(col));
    for (int k = 0; k < n; k++) begin
      exp = (col + k < lim) ? model[page*PB + col + k] : 8'hFF;
      check(doutByte == exp, req, doutByte, exp);
      doutReq = 1'b1;
      @(negedge clk);
      doutReq = 1'b0;
    end
    spareEn = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < NPG*PB; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(ready == 1'b1, "R2 ready", ready, 1);
    check(doutByte == 8'hFF, "R2 dout", doutByte, 8'hFF);
    chkRead(0, 0, 3, 1'b1, "R2 array");

    // table of program/commit/readback vectors (R3, R1, R9)
    foreach (TABLE[v]) begin
      doOp(2'b01, TABLE[v].page, TABLE[v].col);
      pushData(int'(TABLE[v].n), TABLE[v].fill);
      doOp(2'b10, 5'd0, 7'd0);
      waitBusy(cnt);
      check(cnt == BUSY, "R9 commit busy", cnt, BUSY);
      modelCommit(TABLE[v].page, TABLE[v].col, TABLE[v].n, TABLE[v].fill);
      doOp(2'b00, TABLE[v].page, TABLE[v].col);
      check(doutByte == TABLE[v].expFirst, "R3 first byte", doutByte, TABLE[v].expFirst);
      chkRead(TABLE[v].page, TABLE[v].col, int'(TABLE[v].n) + 1, 1'b1, "R3 readback");
    end

    // R10: inputs during busy are ignored
    doOp(2'b00, 5'd1, 7'd3);
    doOp(2'b01, 5'd7, 7'd0);
    pushData(1, 8'h0F);
    doOp(2'b10, 5'd0, 7'd0);
    modelCommit(7, 0, 1, 8'h0F);
    doOp(2'b00, 5'd5, 7'd64);
    pushData(3, 8'h00);
    doOp(2'b11, 5'd1, 7'd0);
    waitBusy(cnt);
    check(doutByte == (8'hA5 ^ 8'h03), "R10 read pos kept", doutByte, 8'hA5 ^ 8'h03);
    doOp(2'b01, 5'd8, 7'd0);
    doOp(2'b10, 5'd0, 7'd0);
    waitBusy(cnt);
    chkRead(8, 0, 2, 1'b1, "R10 dropped data");
    chkRead(7, 0, 2, 1'b1, "R10 commit");
    chkRead(1, 0, 2, 1'b1, "R10 erase ignored");

    // R6: write protect
    wrAllow = 1'b0;
    doOp(2'b01, 5'd4, 7'd0);
    pushData(2, 8'h00);
    doOp(2'b10, 5'd0, 7'd0);
    check(ready == 1'b1, "R6 commit ready", ready, 1);
    doOp(2'b11, 5'd1, 7'd0);
    check(ready == 1'b1, "R6 erase ready", ready, 1);
    chkRead(4, 0, 2, 1'b1, "R6 no program");
    chkRead(1, 0, 2, 1'b1, "R6 no erase");
    wrAllow = 1'b1;

    // R8: out-of-range page
    doOp(2'b01, 5'd20, 7'd0);
    pushData(2, 8'h00);
    doOp(2'b10, 5'd0, 7'd0);
    check(ready == 1'b1, "R8 commit ready", ready, 1);
    doOp(2'b11, 5'd20, 7'd0);
    check(ready == 1'b1, "R8 erase ready", ready, 1);
    doOp(2'b00, 5'd1, 7'd0);
    doOp(2'b00, 5'd20, 7'd0);
    check(doutByte == 8'hA5, "R8 read pos kept", doutByte, 8'hA5);

    // R4 buffer cap, R7/R1 read limits
    doOp(2'b01, 5'd6, 7'd0);
    pushData(70, 8'h00);
    doOp(2'b10, 5'd0, 7'd0);
    waitBusy(cnt);
    modelCommit(6, 0, 70, 8'h00);
    chkRead(6, 0, 68, 1'b1, "R4 full page");
    chkRead(6, 62, 4, 1'b0, "R7 main only");
    chkRead(6, 62, 6, 1'b1, "R7 with spare");
    chkRead(6, 64, 3, 1'b0, "R1 spare hidden");

    // R5 block erase, page 5 -> pages 4..7
    doOp(2'b11, 5'd5, 7'd0);
    waitBusy(cnt);
    check(cnt == BUSY, "R9 erase busy", cnt, BUSY);
    for (int p = 4; p < 8; p++)
      for (int c = 0; c < PB; c++) model[p*PB + c] = 8'hFF;
    chkRead(5, 64, 2, 1'b1, "R5 spare erased");
    chkRead(6, 0, 3, 1'b1, "R5 page6");
    chkRead(7, 0, 2, 1'b1, "R5 page7");
    chkRead(4, 65, 1, 1'b1, "R5 page4");
    chkRead(3, 60, 2, 1'b1, "R5 other block");
    chkRead(8, 0, 1, 1'b1, "R5 next block");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule